// File: doc/BRIEF.md
# Interrupt Source Steering Router

This block takes a vector of level-sensitive interrupt requests from on-chip peripherals and decides, for every request, which one of three consumers serves it. The consumers are the DMA channels, a data transfer controller, and the CPU interrupt controller. Each DMA channel names one source as its activation trigger. Once a channel is armed, it owns that source outright. A source that no channel owns goes to the transfer controller when its transfer-enable bit is set, and to the CPU when the bit is clear.

When the consumer that serves a request accepts it, the router sends a one-clock clear pulse back to the source that raised it. There is one exception. When the transfer controller reports that a transfer ended with a hand-back event, the router clears that source's transfer-enable bit and sends no clear pulse. The request, still asserted, then appears on the CPU path. A hand-back event is either the per-transfer interrupt option for that source or a transfer count that has run out. The router also compares the three consumer priorities and flags any configuration in which the CPU outranks a transfer path.

Top module: `irq_steer_router`

## Requirements
- R1: Channel c owns the source numbered by its select field only while its 2-bit mode field equals binary 10 (module-interrupt activation), its enable bit is 1 and its allow bit is 1. While it owns that source, `dma_act[c]` follows the request, except in a cycle where that source's clear pulse is high.
- R2: When several armed channels select the same source, only the lowest-numbered of them owns it and raises `dma_act`. The others stay idle.
- R3: A source owned by a DMA channel never shows up on `xfer_vld`/`xfer_vec` or on `cpu_vld`/`cpu_vec`.
- R4: A pending source that no channel owns is offered to the transfer controller when its `xfer_en` bit is 1, and to the CPU when the bit is 0. On each path the lowest-numbered eligible source wins, and its number is driven on that path's vector output.
- R5: An accept is one of three events: `dma_ack[c]` while `dma_act[c]` is high, `xfer_ack` while `xfer_vld` is high with no hand-back event, or `cpu_ack` while `cpu_vld` is high. Each accept produces a single-cycle `src_clr` pulse on the accepted source in the following cycle. An ack strobe with no matching valid is ignored.
- R6: An accepted transfer on a source whose `xfer_disel` bit is 1 clears that source's `xfer_en` bit in the next cycle. No clear pulse is issued, and the still-asserted request moves to the CPU path.
- R7: An accepted transfer with `xfer_cnt_zero` high behaves the same way as in R6, whatever the value of `xfer_disel`.
- R8: `prio_fault[0]` is 1 exactly when `cpu_prio` > `dma_prio`, and `prio_fault[1]` is 1 exactly when `cpu_prio` > `xfer_prio` (unsigned compare).
- R9: After reset, `xfer_en`, `src_clr`, `dma_act`, `xfer_vld` and `cpu_vld` are all 0. Each 1 bit of `xfer_en_set` sets the matching `xfer_en` bit in the next cycle. If a hand-back and a set hit the same bit in the same cycle, the hand-back wins.
- R10: During the cycle in which a source's clear pulse is high, that source is offered to no consumer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | NUM_SRC | Level interrupt requests, one per source |
| src_clr | output | NUM_SRC | One-cycle clear pulse back to each source |
| ch_sel | input | NUM_CH*SRC_W | Source number selected by each DMA channel |
| ch_mode | input | NUM_CH*2 | Transfer-mode field per channel, 10 = module interrupt |
| ch_en | input | NUM_CH | Channel enable per channel |
| ch_allow | input | NUM_CH | Activation-allow bit per channel |
| dma_act | output | NUM_CH | Activation request per DMA channel |
| dma_ack | input | NUM_CH | Accept strobe per DMA channel |
| xfer_en_set | input | NUM_SRC | Set pulses for the transfer-enable bits |
| xfer_disel | input | NUM_SRC | Per-transfer CPU interrupt option per source |
| xfer_en | output | NUM_SRC | Current transfer-enable bits |
| xfer_vld | output | 1 | Request offered to the transfer controller |
| xfer_vec | output | SRC_W | Source number offered to the transfer controller |
| xfer_ack | input | 1 | Transfer controller accept strobe |
| xfer_cnt_zero | input | 1 | With `xfer_ack`: the transfer count has reached zero |
| cpu_vld | output | 1 | Request offered to the CPU |
| cpu_vec | output | SRC_W | Source number offered to the CPU |
| cpu_ack | input | 1 | CPU accept strobe |
| cpu_prio | input | PRIO_W | CPU path priority |
| dma_prio | input | PRIO_W | DMA path priority |
| xfer_prio | input | PRIO_W | Transfer controller path priority |
| prio_fault | output | 2 | Bit 0: CPU above DMA; bit 1: CPU above transfer controller |

## Verification
The assertions check on every cycle that an owned source never leaks onto the transfer or CPU path, that a source whose clear pulse is high is offered nowhere, that clear pulses last one cycle and follow their accepts, that hand-back clears the enable bit without a pulse, and that each path only carries sources with the matching enable value. Other properties hold only across whole scenarios, so only the bench can show them. These are the lowest-channel tie-break on a shared source, the lowest-index choice among many pending sources, the full migration of a handed-back request to the CPU followed by its own clear, and the priority-fault flags over every priority combination.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

  localparam int MODE_W = 2;
  localparam logic [MODE_W-1:0] MODE_MODULE_IRQ = 2'b10;

  // A channel is armed when its mode selects module-interrupt activation
  // and both of its gating bits are set.
  function automatic logic chan_armed(input logic [MODE_W-1:0] mode,
                                      input logic en,
                                      input logic allow);
    return (mode == MODE_MODULE_IRQ) && en && allow;
  endfunction

  // The CPU path outranks a transfer path when its priority value is larger.
  function automatic logic prio_exceeds(input int unsigned cpu_p,
                                        input int unsigned path_p);
    return cpu_p > path_p;
  endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  cand,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |cand;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_dma_owner.sv
module irq_dma_owner
  import irq_steer_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CH  = 4,
  parameter int SRC_W   = 4
) (
  input  logic [NUM_CH*SRC_W-1:0]  ch_sel,
  input  logic [NUM_CH*MODE_W-1:0] ch_mode,
  input  logic [NUM_CH-1:0]        ch_en,
  input  logic [NUM_CH-1:0]        ch_allow,
  output logic [NUM_CH-1:0]        ch_owns,
  output logic [NUM_SRC-1:0]       own_mask
);
  logic [NUM_CH-1:0] armed;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_arm
      assign armed[g] = chan_armed(ch_mode[g*MODE_W +: MODE_W], ch_en[g], ch_allow[g]);
    end
  endgenerate

  // Channels are visited in ascending order, so a source that a lower
  // channel has already claimed is refused to every higher one.
  always_comb begin
    own_mask = '0;
    ch_owns  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (armed[c] && (int'(ch_sel[c*SRC_W +: SRC_W]) < NUM_SRC)) begin
        if (!own_mask[ch_sel[c*SRC_W +: SRC_W]]) begin
          ch_owns[c] = 1'b1;
          own_mask[ch_sel[c*SRC_W +: SRC_W]] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_clear_ctl.sv
module irq_clear_ctl #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] accept_mask,
  input  logic [NUM_SRC-1:0] handback_mask,
  input  logic [NUM_SRC-1:0] en_set,
  output logic [NUM_SRC-1:0] clr_q,
  output logic [NUM_SRC-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= '0;
      en_q  <= '0;
    end else begin
      clr_q <= accept_mask;
      en_q  <= (en_q | en_set) & ~handback_mask;
    end
  end
endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
  import irq_steer_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CH  = 4,
  parameter int PRIO_W  = 3,
  parameter int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_req,
  output logic [NUM_SRC-1:0]        src_clr,
  input  logic [NUM_CH*SRC_W-1:0]   ch_sel,
  input  logic [NUM_CH*MODE_W-1:0]  ch_mode,
  input  logic [NUM_CH-1:0]         ch_en,
  input  logic [NUM_CH-1:0]         ch_allow,
  output logic [NUM_CH-1:0]         dma_act,
  input  logic [NUM_CH-1:0]         dma_ack,
  input  logic [NUM_SRC-1:0]        xfer_en_set,
  input  logic [NUM_SRC-1:0]        xfer_disel,
  output logic [NUM_SRC-1:0]        xfer_en,
  output logic                      xfer_vld,
  output logic [SRC_W-1:0]          xfer_vec,
  input  logic                      xfer_ack,
  input  logic                      xfer_cnt_zero,
  output logic                      cpu_vld,
  output logic [SRC_W-1:0]          cpu_vec,
  input  logic                      cpu_ack,
  input  logic [PRIO_W-1:0]         cpu_prio,
  input  logic [PRIO_W-1:0]         dma_prio,
  input  logic [PRIO_W-1:0]         xfer_prio,
  output logic [1:0]                prio_fault
);
  localparam logic [NUM_SRC-1:0] ONE_SRC = NUM_SRC'(1);

  // Internal events, named for the checker.
  logic [NUM_CH-1:0]  ch_owns;
  logic [NUM_SRC-1:0] own_mask;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] xfer_elig;
  logic [NUM_SRC-1:0] cpu_elig;
  logic [NUM_SRC-1:0] dma_accept;
  logic [NUM_SRC-1:0] accept_mask;
  logic [NUM_SRC-1:0] handback_mask;
  logic               xfer_take;
  logic               xfer_handback;
  logic               cpu_take;

  irq_dma_owner #(.NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH), .SRC_W(SRC_W)) u_owner (
    .ch_sel   (ch_sel),
    .ch_mode  (ch_mode),
    .ch_en    (ch_en),
    .ch_allow (ch_allow),
    .ch_owns  (ch_owns),
    .own_mask (own_mask)
  );

  // DMA activation: owner, live request, source not in its clear cycle.
  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_dma
      logic [SRC_W-1:0] s;
      assign s = ch_sel[g*SRC_W +: SRC_W];
      assign dma_act[g] = ch_owns[g] && src_req[s] && !src_clr[s];
    end
  endgenerate

  always_comb begin
    dma_accept = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (dma_act[c] && dma_ack[c])
        dma_accept = dma_accept | (ONE_SRC << ch_sel[c*SRC_W +: SRC_W]);
    end
  end

  // Steering of sources that no channel owns.
  assign pend      = src_req & ~own_mask & ~src_clr;
  assign xfer_elig = pend & xfer_en;
  assign cpu_elig  = pend & ~xfer_en;

  irq_prio_pick #(.N(NUM_SRC), .IW(SRC_W)) u_pick_xfer (
    .cand (xfer_elig),
    .any  (xfer_vld),
    .idx  (xfer_vec)
  );

  irq_prio_pick #(.N(NUM_SRC), .IW(SRC_W)) u_pick_cpu (
    .cand (cpu_elig),
    .any  (cpu_vld),
    .idx  (cpu_vec)
  );

  // Accept handling and hand-back to the CPU.
  assign xfer_take     = xfer_vld && xfer_ack;
  assign xfer_handback = xfer_take && (xfer_cnt_zero || xfer_disel[xfer_vec]);
  assign cpu_take      = cpu_vld && cpu_ack;

  assign handback_mask = xfer_handback ? (ONE_SRC << xfer_vec) : '0;
  assign accept_mask   = dma_accept
                       | ((xfer_take && !xfer_handback) ? (ONE_SRC << xfer_vec) : '0)
                       | (cpu_take ? (ONE_SRC << cpu_vec) : '0);

  irq_clear_ctl #(.NUM_SRC(NUM_SRC)) u_clr (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept_mask   (accept_mask),
    .handback_mask (handback_mask),
    .en_set        (xfer_en_set),
    .clr_q         (src_clr),
    .en_q          (xfer_en)
  );

  assign prio_fault[0] = prio_exceeds(int'(cpu_prio), int'(dma_prio));
  assign prio_fault[1] = prio_exceeds(int'(cpu_prio), int'(xfer_prio));

endmodule

// File: rtl/irq_steer_checker.sv
module irq_steer_checker
  import irq_steer_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CH  = 4,
  parameter int SRC_W   = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_SRC-1:0]        src_clr,
  input logic [NUM_CH*SRC_W-1:0]   ch_sel,
  input logic [NUM_CH*MODE_W-1:0]  ch_mode,
  input logic [NUM_CH-1:0]         ch_en,
  input logic [NUM_CH-1:0]         ch_allow,
  input logic [NUM_CH-1:0]         dma_act,
  input logic [NUM_SRC-1:0]        own_mask,
  input logic [NUM_SRC-1:0]        xfer_en,
  input logic                      xfer_vld,
  input logic [SRC_W-1:0]          xfer_vec,
  input logic                      cpu_vld,
  input logic [SRC_W-1:0]          cpu_vec,
  input logic                      cpu_take,
  input logic                      xfer_take,
  input logic                      xfer_handback
);
  genvar c, d;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      assert_dma_owner_cond_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dma_act[c] |-> (ch_mode[c*MODE_W +: MODE_W] == MODE_MODULE_IRQ) && ch_en[c] && ch_allow[c]);
      for (d = 0; d < c; d++) begin : g_low
        assert_low_channel_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
          dma_act[c] |-> !((ch_sel[d*SRC_W +: SRC_W] == ch_sel[c*SRC_W +: SRC_W]) &&
                           (ch_mode[d*MODE_W +: MODE_W] == MODE_MODULE_IRQ) &&
                           ch_en[d] && ch_allow[d]));
      end
    end
  endgenerate

  assert_owned_not_on_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_vld |-> !own_mask[xfer_vec]);
  assert_owned_not_on_cpu_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_vld |-> !own_mask[cpu_vec]);

  assert_xfer_path_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_vld |-> xfer_en[xfer_vec]);
  assert_cpu_path_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_vld |-> !xfer_en[cpu_vec]);

  assert_clear_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_clr & $past(src_clr)) == '0);
  assert_cpu_accept_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_take |=> src_clr[$past(cpu_vec)]);
  assert_xfer_accept_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_take && !xfer_handback) |=> src_clr[$past(xfer_vec)]);

  assert_handback_no_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_handback |=> !xfer_en[$past(xfer_vec)] && !src_clr[$past(xfer_vec)]);

  assert_clearing_not_offered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_vld |-> !src_clr[xfer_vec]) and (cpu_vld |-> !src_clr[cpu_vec]));
endmodule

bind irq_steer_router irq_steer_checker #(
  .NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH), .SRC_W(SRC_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .src_clr       (src_clr),
  .ch_sel        (ch_sel),
  .ch_mode       (ch_mode),
  .ch_en         (ch_en),
  .ch_allow      (ch_allow),
  .dma_act       (dma_act),
  .own_mask      (own_mask),
  .xfer_en       (xfer_en),
  .xfer_vld      (xfer_vld),
  .xfer_vec      (xfer_vec),
  .cpu_vld       (cpu_vld),
  .cpu_vec       (cpu_vec),
  .cpu_take      (cpu_take),
  .xfer_take     (xfer_take),
  .xfer_handback (xfer_handback)
);

// File: tb/sim_irq_steer_router.sv
`timescale 1ns/1ps
module sim_irq_steer_router;
  localparam int NS = 16;
  localparam int NC = 4;
  localparam int PW = 3;
  localparam int SW = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NS-1:0]   src_req;
  logic [NS-1:0]   src_clr;
  logic [NC*SW-1:0] ch_sel;
  logic [NC*2-1:0] ch_mode;
  logic [NC-1:0]   ch_en, ch_allow, dma_act, dma_ack;
  logic [NS-1:0]   xfer_en_set, xfer_disel, xfer_en;
  logic            xfer_vld, xfer_ack, xfer_cnt_zero, cpu_vld, cpu_ack;
  logic [SW-1:0]   xfer_vec, cpu_vec;
  logic [PW-1:0]   cpu_prio, dma_prio, xfer_prio;
  logic [1:0]      prio_fault;

  int checks = 0;
  int errors = 0;
  logic [NS-1:0] en_model;

  always #4 clk = ~clk;

  irq_steer_router #(.NUM_SRC(NS), .NUM_CH(NC), .PRIO_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_clr(src_clr),
    .ch_sel(ch_sel), .ch_mode(ch_mode), .ch_en(ch_en), .ch_allow(ch_allow),
    .dma_act(dma_act), .dma_ack(dma_ack),
    .xfer_en_set(xfer_en_set), .xfer_disel(xfer_disel), .xfer_en(xfer_en),
    .xfer_vld(xfer_vld), .xfer_vec(xfer_vec), .xfer_ack(xfer_ack),
    .xfer_cnt_zero(xfer_cnt_zero), .cpu_vld(cpu_vld), .cpu_vec(cpu_vec),
    .cpu_ack(cpu_ack), .cpu_prio(cpu_prio), .dma_prio(dma_prio),
    .xfer_prio(xfer_prio), .prio_fault(prio_fault)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_ch(input int c, input int sel, input logic [1:0] mode,
                        input logic en, input logic allow);
    ch_sel[c*SW +: SW] = SW'(sel);
    ch_mode[c*2 +: 2]  = mode;
    ch_en[c]           = en;
    ch_allow[c]        = allow;
  endtask

  // Index of the lowest set bit, scanning upward; -1 encodes "none".
  function automatic int first_set(input logic [NS-1:0] m);
    for (int i = 0; i < NS; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic expect_paths(input string req, input logic [NS-1:0] r);
    int xi, ci;
    xi = first_set(r & en_model);
    ci = first_set(r & ~en_model);
    check({req, " xfer_vld"}, 32'(xfer_vld), 32'(xi >= 0));
    check({req, " cpu_vld"},  32'(cpu_vld),  32'(ci >= 0));
    if (xi >= 0) check({req, " xfer_vec"}, 32'(xfer_vec), 32'(xi));
    if (ci >= 0) check({req, " cpu_vec"},  32'(cpu_vec),  32'(ci));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_req = '0; ch_sel = '0; ch_mode = '0; ch_en = '0; ch_allow = '0;
    dma_ack = '0; xfer_en_set = '0; xfer_disel = '0; xfer_ack = 1'b0;
    xfer_cnt_zero = 1'b0; cpu_ack = 1'b0; cpu_prio = '0; dma_prio = '0; xfer_prio = '0;
    en_model = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset xfer_en", 32'(xfer_en), 0);
    check("R9 reset src_clr", 32'(src_clr), 0);
    check("R9 reset valids", {29'd0, xfer_vld, cpu_vld, |dma_act}, 0);
    rst_n = 1'b1;
    step();

    // R8 exhaustive priority sweep
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int x = 0; x < 8; x++) begin
          cpu_prio = PW'(a); dma_prio = PW'(b); xfer_prio = PW'(x);
          #1;
          check("R8 prio_fault", 32'(prio_fault), {30'd0, a > x, a > b});
        end

    // R9 setting enable bits
    xfer_en_set = 16'hA5C3;
    step();
    xfer_en_set = '0;
    en_model = 16'hA5C3;
    check("R9 xfer_en after set", 32'(xfer_en), 32'(en_model));

    // R4 single-source sweep
    for (int s = 0; s < NS; s++) begin
      src_req = NS'(1) << s;
      #1;
      expect_paths("R4 single", src_req);
    end
    // R4 multi-source patterns, lowest index wins per path
    for (int k = 1; k < 40; k++) begin
      src_req = NS'(k * 16'h1357) ^ NS'(k << 5);
      #1;
      expect_paths("R4 multi", src_req);
    end

    // R1 owner condition sweep on channel 0, source 9 (CPU-routed when free)
    src_req = NS'(1) << 9;
    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 2; e++)
        for (int al = 0; al < 2; al++) begin
          logic own;
          set_ch(0, 9, 2'(m), e[0], al[0]);
          #1;
          own = (m == 2) && (e == 1) && (al == 1);
          check("R1 dma_act", 32'(dma_act), 32'(own));
          check("R3 cpu_vld hidden when owned", 32'(cpu_vld), 32'(!own));
          check("R3 xfer_vld", 32'(xfer_vld), 0);
        end
    set_ch(0, 0, 2'b00, 1'b0, 1'b0);

    // R2 shared source: lowest armed channel wins
    src_req = NS'(1) << 3;
    set_ch(0, 3, 2'b10, 1, 1); set_ch(1, 3, 2'b10, 1, 1); set_ch(2, 3, 2'b10, 1, 1);
    #1; check("R2 ch0 wins", 32'(dma_act), 32'h1);
    ch_en[0] = 1'b0;
    #1; check("R2 ch1 wins", 32'(dma_act), 32'h2);
    ch_mode[2 +: 2] = 2'b01;
    #1; check("R2 ch2 wins", 32'(dma_act), 32'h4);
    check("R3 shared owned hidden", {30'd0, xfer_vld, cpu_vld}, 0);
    for (int c = 0; c < NC; c++) set_ch(c, 0, 2'b00, 0, 0);

    // R5 CPU accept, R10 exclusion in clear cycle
    src_req = NS'(1) << 9;
    #1; check("R5 cpu offered", {27'd0, cpu_vld, cpu_vec}, {27'd0, 1'b1, 4'd9});
    cpu_ack = 1'b1;
    step();
    cpu_ack = 1'b0;
    check("R5 cpu clear pulse", 32'(src_clr), 32'h200);
    check("R10 cpu not offered while clearing", 32'(cpu_vld), 0);
    src_req = '0;
    step();
    check("R5 clear is one cycle", 32'(src_clr), 0);

    // R5 ack without valid ignored
    cpu_ack = 1'b1; xfer_ack = 1'b1; dma_ack = '1;
    step();
    cpu_ack = 1'b0; xfer_ack = 1'b0; dma_ack = '0;
    check("R5 stray ack no clear", 32'(src_clr), 0);
    check("R5 stray ack xfer_en kept", 32'(xfer_en), 32'(en_model));

    // R5 DMA accept
    set_ch(2, 11, 2'b10, 1, 1);
    src_req = NS'(1) << 11;
    #1; check("R5 dma_act ch2", 32'(dma_act), 32'h4);
    dma_ack = 4'b0100;
    step();
    dma_ack = '0;
    check("R5 dma clear pulse", 32'(src_clr), 32'h800);
    check("R10 dma idle while clearing", 32'(dma_act), 0);
    src_req = '0;
    set_ch(2, 0, 2'b00, 0, 0);
    step();

    // R5 plain transfer accept keeps the enable bit
    src_req = NS'(1);
    #1; check("R5 xfer offered", {27'd0, xfer_vld, xfer_vec}, {27'd0, 1'b1, 4'd0});
    xfer_ack = 1'b1;
    step();
    xfer_ack = 1'b0;
    check("R5 xfer clear pulse", 32'(src_clr), 32'h1);
    check("R5 xfer_en kept", 32'(xfer_en), 32'(en_model));
    src_req = '0;
    step();

    // R6 per-transfer hand-back on source 1
    xfer_disel = NS'(1) << 1;
    src_req = NS'(1) << 1;
    #1; check("R6 xfer offered", {27'd0, xfer_vld, xfer_vec}, {27'd0, 1'b1, 4'd1});
    xfer_ack = 1'b1;
    step();
    xfer_ack = 1'b0;
    en_model[1] = 1'b0;
    check("R6 no clear pulse", 32'(src_clr), 0);
    check("R6 enable cleared", 32'(xfer_en), 32'(en_model));
    check("R6 moved to cpu", {26'd0, xfer_vld, cpu_vld, cpu_vec}, {26'd0, 1'b0, 1'b1, 4'd1});
    cpu_ack = 1'b1;
    step();
    cpu_ack = 1'b0;
    check("R6 cpu accept clears", 32'(src_clr), 32'h2);
    src_req = '0; xfer_disel = '0;
    step();

    // R7 end-of-count hand-back on source 7
    src_req = NS'(1) << 7;
    #1; check("R7 xfer offered", {27'd0, xfer_vld, xfer_vec}, {27'd0, 1'b1, 4'd7});
    xfer_ack = 1'b1; xfer_cnt_zero = 1'b1;
    step();
    xfer_ack = 1'b0; xfer_cnt_zero = 1'b0;
    en_model[7] = 1'b0;
    check("R7 no clear pulse", 32'(src_clr), 0);
    check("R7 enable cleared", 32'(xfer_en), 32'(en_model));
    check("R7 moved to cpu", {27'd0, cpu_vld, cpu_vec}, {27'd0, 1'b1, 4'd7});
    src_req = '0;
    step();

    // R9 hand-back beats a same-cycle set (source 0)
    src_req = NS'(1);
    xfer_ack = 1'b1; xfer_cnt_zero = 1'b1; xfer_en_set = NS'(1);
    step();
    xfer_ack = 1'b0; xfer_cnt_zero = 1'b0; xfer_en_set = '0;
    en_model[0] = 1'b0;
    check("R9 clear beats set", 32'(xfer_en), 32'(en_model));
    src_req = '0;
    step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule